// File: doc/BRIEF.md
# Comparator Bank Window Sequencer

This block is the digital controller for a bank of eight voltage comparators inside a microcontroller peripheral. A bus write to the result register opens a comparison window of fixed length. For the whole window the block powers the reference ladder and connects the comparators to their inputs. On the last cycle of the window it samples all eight comparator outputs together into the result register, and software then reads that register. The ladder is unpowered at every other time, so it draws no current between conversions.

A separate byte-wide control register holds the reference choice in one bit. When that bit is 1 the comparators use a fixed internal level, nominally 29/32 of supply. When it is 0 they use an external reference pin. The analog ladder, the reference multiplexer and the comparators sit outside this block, and it sees them only as digital signals. A window runs once per write: the block never starts a comparison by itself.

Top module: `cmp_bank_seq`

## Requirements
- R1: In the cycle after a synchronous reset, `result_q` is 0, `busy`, `ladder_en` and `cmp_connect` are 0, `ctrl_q` is 0 and `ref_internal` is 0 (external reference).
- R2: A cycle with `data_wr` high starts a comparison window, and `busy` is 1 in the next cycle.
- R3: One write with no further writes keeps `busy`, `ladder_en` and `cmp_connect` high for exactly 14 consecutive cycles, starting with the cycle after the write.
- R4: Outside a window, `ladder_en` and `cmp_connect` are 0.
- R5: `cmp_in` is sampled during the 14th cycle of the window, and its value appears on `result_q` in the following cycle. Bit i is 1 when channel i is above the reference and 0 when it is below; all eight channels are captured together.
- R6: During a window, `result_q` keeps the result of the previous comparison.
- R7: A write during an active window restarts the count. The window then ends 14 cycles after the latest write, and nothing is captured at the end the earlier write would have had.
- R8: After a result is stored, `result_q` does not change however `cmp_in` moves, until another write completes a window.
- R9: A cycle with `ctrl_wr` high loads `ctrl_wdata` into `ctrl_q`. `ref_internal` follows bit 7 of `ctrl_q`: 1 selects the internal fixed level and 0 selects the external pin.
- R10: Writes to the result register (`data_wr`) leave `ctrl_q` and `ref_internal` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Write strobe for the result register; starts a window |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control register write data; bit 7 selects the reference |
| cmp_in | input | 8 | Comparator outputs, 1 = channel above reference |
| result_q | output | 8 | Latched comparison result |
| busy | output | 1 | High while a window is running |
| ladder_en | output | 1 | Powers the reference ladder |
| cmp_connect | output | 1 | Connects the comparators to their inputs |
| ref_internal | output | 1 | 1 = internal fixed reference, 0 = external pin |
| ctrl_q | output | 8 | Control register contents |

## Verification
If the window counter is off by even one state, `busy` and `ladder_en` fall a cycle early or late. If the capture is misplaced, `result_q` takes the value `cmp_in` had in a cycle other than the 14th. Because the bench changes `cmp_in` in every cycle, such a fault shows up within one window. A capture that fires when it should not, such as at the end of an aborted window or while idle, changes `result_q` at a moment when the reference model holds it steady. The model is compared with every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;

    localparam int unsigned CH_COUNT  = 8;
    localparam int unsigned WIN_LEN   = 14;
    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned REF_BIT   = 7;

    typedef enum logic {
        REF_EXTERNAL = 1'b0,
        REF_INTERNAL = 1'b1
    } ref_src_e;

    // Returns 1 when count value cnt is the last cycle of a window of length len.
    function automatic logic win_is_last(input int unsigned cnt, input int unsigned len);
        return cnt == len - 1;
    endfunction

endpackage

// File: rtl/cmp_window_timer.sv
module cmp_window_timer #(
    parameter int unsigned WIN_CYC = cmp_seq_pkg::WIN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic capture
);
    localparam int unsigned CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st;
    logic       last;

    always_comb begin
        last    = st.run && cmp_seq_pkg::win_is_last(int'(st.cnt), WIN_CYC);
        active  = st.run;
        capture = last && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (start) begin
            st.run <= 1'b1;
            st.cnt <= '0;
        end else if (st.run) begin
            if (last) begin
                st <= '0;
            end else begin
                st.cnt <= st.cnt + 1'b1;
            end
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        st.run |-> (int'(st.cnt) < WIN_CYC));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (st.run && st.cnt == '0));

    // R3
    window_end_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> !st.run);

    // R4
    stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.run && !start) |=> !st.run);

endmodule

// File: rtl/cmp_result_reg.sv
module cmp_result_reg #(
    parameter int unsigned N_CH = cmp_seq_pkg::CH_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [N_CH-1:0] cmp_in,
    output logic [N_CH-1:0] result
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (capture) begin
            result <= cmp_in;
        end
    end

    // R5
    capture_val_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (result == $past(cmp_in)));

    // R6
    hold_val_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(result));

endmodule

// File: rtl/cmp_ref_ctrl.sv
module cmp_ref_ctrl #(
    parameter int unsigned CW   = cmp_seq_pkg::CTRL_W,
    parameter int unsigned RBIT = cmp_seq_pkg::REF_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] ctrl,
    output cmp_seq_pkg::ref_src_e ref_src
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl <= wdata;
        end
    end

    assign ref_src = cmp_seq_pkg::ref_src_e'(ctrl[RBIT]);

    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctrl == $past(wdata)));

    // R10
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl));

endmodule

// File: rtl/cmp_bank_seq.sv
module cmp_bank_seq
    import cmp_seq_pkg::*;
#(
    parameter int unsigned N_CH    = CH_COUNT,
    parameter int unsigned WIN_CYC = WIN_LEN,
    parameter int unsigned CW      = CTRL_W,
    parameter int unsigned RBIT    = REF_BIT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_wr,
    input  logic            ctrl_wr,
    input  logic [CW-1:0]   ctrl_wdata,
    input  logic [N_CH-1:0] cmp_in,
    output logic [N_CH-1:0] result_q,
    output logic            busy,
    output logic            ladder_en,
    output logic            cmp_connect,
    output logic            ref_internal,
    output logic [CW-1:0]   ctrl_q
);
    logic     win_active;
    logic     win_capture;
    ref_src_e ref_src;

    cmp_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (data_wr),
        .active  (win_active),
        .capture (win_capture)
    );

    cmp_result_reg #(.N_CH(N_CH)) u_result (
        .clk     (clk),
        .rst     (rst),
        .capture (win_capture),
        .cmp_in  (cmp_in),
        .result  (result_q)
    );

    cmp_ref_ctrl #(.CW(CW), .RBIT(RBIT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wdata   (ctrl_wdata),
        .ctrl    (ctrl_q),
        .ref_src (ref_src)
    );

    always_comb begin
        busy         = win_active;
        ladder_en    = win_active;
        cmp_connect  = win_active;
        ref_internal = (ref_src == REF_INTERNAL);
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> busy);

    // R8
    idle_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !data_wr) |=> $stable(result_q));

endmodule

// File: tb/test_cmp_bank_seq.sv
module test_cmp_bank_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_wr = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] cmp_in = 8'h3C;
    logic [7:0] result_q;
    logic       busy, ladder_en, cmp_connect, ref_internal;
    logic [7:0] ctrl_q;

    int checks = 0;
    int errors = 0;
    int m_cnt  = -1;
    int m_res  = 0;
    int m_ctrl = 0;
    bit model_ok = 1'b0;

    always #4 clk = ~clk;

    cmp_bank_seq i_cmp_bank_seq (
        .clk(clk), .rst(rst), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .cmp_in(cmp_in), .result_q(result_q),
        .busy(busy), .ladder_en(ladder_en), .cmp_connect(cmp_connect),
        .ref_internal(ref_internal), .ctrl_q(ctrl_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = -1; m_res = 0; m_ctrl = 0;
        end else begin
            if (data_wr) m_cnt = 0;
            else if (m_cnt == 13) begin m_res = int'(cmp_in); m_cnt = -1; end
            else if (m_cnt >= 0) m_cnt++;
            if (ctrl_wr) m_ctrl = int'(ctrl_wdata);
        end
        model_ok = 1'b1;
    end

    // Per-cycle comparison and input stirring, away from the active edge
    always @(negedge clk) begin
        if (model_ok) begin
            chk("R3/R4 busy", int'(busy), int'(m_cnt >= 0));
            chk("R3/R4 ladder_en", int'(ladder_en), int'(m_cnt >= 0));
            chk("R3/R4 cmp_connect", int'(cmp_connect), int'(m_cnt >= 0));
            chk("R5/R6/R8 result_q", int'(result_q), m_res);
            chk("R9 ctrl_q", int'(ctrl_q), m_ctrl);
            chk("R9 ref_internal", int'(ref_internal), (m_ctrl >> 7) & 1);
        end
        cmp_in <= cmp_in * 8'd5 + 8'd29;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_data();
        data_wr = 1'b1; @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1; @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic window_len(input string tag);
        int n = 0;
        while (busy && n < 40) begin n++; @(negedge clk); end
        chk(tag, n, 14);
    endtask

    initial begin
        int watchdog = 0;
        fork
            begin
                while (watchdog < 5000) begin @(posedge clk); watchdog++; end
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
    end

    initial begin
        logic [7:0] held;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 result_q", int'(result_q), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ladder_en", int'(ladder_en), 0);
        chk("R1 ref_internal", int'(ref_internal), 0);
        chk("R1 ctrl_q", int'(ctrl_q), 0);

        // R2 / R3 single window
        write_data();
        chk("R2 busy after write", int'(busy), 1);
        window_len("R3 window length");
        chk("R4 ladder off after window", int'(ladder_en), 0);
        held = result_q;

        // R8 no new comparison without write
        cyc(30);
        chk("R8 result held while idle", int'(result_q), int'(held));

        // R6 old result visible during window
        write_data();
        cyc(6);
        chk("R6 old result during window", int'(result_q), int'(held));
        // R7 restart mid window
        write_data();
        window_len("R7 window after restart");

        // R7 write on final cycle of window
        write_data();
        cyc(13);
        held = result_q;
        write_data();
        chk("R7 no capture at aborted end", int'(result_q), int'(held));
        window_len("R7 window after last-cycle restart");

        // R9 reference select
        write_ctrl(8'h80);
        chk("R9 internal ref", int'(ref_internal), 1);
        write_ctrl(8'h7F);
        chk("R9 external ref", int'(ref_internal), 0);
        write_ctrl(8'hC3);
        // R10 data write leaves control alone
        write_data();
        chk("R10 ctrl_q after data write", int'(ctrl_q), 8'hC3);
        chk("R10 ref after data write", int'(ref_internal), 1);
        cyc(20);

        // back-to-back windows
        write_data(); cyc(14);
        write_data();
        window_len("R3 back-to-back window");
        cyc(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule